// File: doc/BRIEF.md
# Keyed Double-Buffered Memory-Map Control

This block sits on an 8-bit peripheral register bus and controls whether a small boot ROM window is overlaid on the address map. Software writes the desired mapping bits into a staging register. Those bits do nothing until a fixed key byte is written to a separate commit register. The commit copies the staged bits into an active copy, and only the active copy steers the address decoder. The active copy can be read back at its own monitor address. A read-only status register shows two further committed mapping enables.

The overlay decoder is combinational. It looks at each code-space or data-space access. When the active boot bit is set and the address falls in the 2 KB window from 0x1000 to 0x17FF, it asserts the boot ROM select. Every other access gets the main memory select. The two selects are never both asserted.

Top module: `memmap_ctl`

## Requirements
- R1: After a synchronous reset, the staging register, the active copy and the status register all read 0x00. With the boot bit of the active copy clear, the boot ROM is not mapped.
- R2: A write to offset 0 stores the control bits in the staging register: bit 0 is the boot overlay enable, bit 1 is the RAM-in-code flag and bit 2 is the vector relocation flag. Offset 0 reads back the stored bits, with bits 7:3 reading 0. A staging write leaves the active copy and the decoder unchanged.
- R3: A write of exactly 0xD5 to offset 1 copies the staging register into the active copy on that same clock edge. The decoder uses the new value from the next cycle onward.
- R4: A write of any other value to offset 1 leaves the active copy unchanged. Offset 1 always reads 0x00.
- R5: Offset 2 reads the active copy, using the same bit layout as offset 0.
- R6: Offset 3 reads the status register:
  - bit 0 is the active RAM-in-code flag;
  - bit 1 is the active vector relocation flag;
  - bits 7:2 read 0;
  - writes to offset 3 change nothing.
- R7: When the active boot bit is 1, an access to an address from 0x1000 to 0x17FF asserts boot_sel, in both code space and data space. Addresses outside that window assert main_sel.
- R8: When the active boot bit is 0, every access asserts main_sel and never boot_sel.
- R9: For every access, exactly one of boot_sel and main_sel is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all register updates happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset on the peripheral bus |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the register selected by bus_addr |
| acc_addr | input | 16 | Address of the current memory access |
| acc_is_data | input | 1 | 1 for a data-space access, 0 for a code-space access |
| boot_sel | output | 1 | Boot ROM select |
| main_sel | output | 1 | Main memory select |

## Verification
Register writes take effect on the rising edge that samples them. A read of offset 0, 2 or 3 therefore shows the new value one cycle after the strobe, and the same holds for the decoder after a commit. The bench drives inputs at the falling edge and samples read data and selects shortly after the next falling edge, which is after the capturing edge has settled. The commit timing is checked on both sides of that edge. Before the edge, boot_sel must still be clear for an in-window address. After the edge, boot_sel must be set. The decoder and the read multiplexer are combinational, so their checks sample a short delay after the address changes, with no clock in between.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int REG_AW = 2;
    localparam int DATA_W = 8;
    localparam int CTL_W  = 3;
    localparam logic [DATA_W-1:0] COMMIT_KEY = 8'hD5;

    typedef enum logic [REG_AW-1:0] {
        OFF_STAGE = 2'd0,
        OFF_KEY   = 2'd1,
        OFF_MON   = 2'd2,
        OFF_STAT  = 2'd3
    } reg_off_e;

    // bit 0 boot overlay, bit 1 RAM-in-code, bit 2 vector relocation
    typedef struct packed {
        logic vec;
        logic ram;
        logic boot;
    } ctl_t;

    function automatic logic [DATA_W-1:0] ctl_to_byte(ctl_t c);
        return {{(DATA_W-CTL_W){1'b0}}, c};
    endfunction

    function automatic logic [DATA_W-1:0] ctl_to_status(ctl_t c);
        return {{(DATA_W-2){1'b0}}, c.vec, c.ram};
    endfunction

endpackage

// File: rtl/memmap_regs.sv
module memmap_regs
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stage,
    input  logic              wr_key,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              stage_q,
    output ctl_t              active_q
);

    logic key_ok;
    assign key_ok = wr_key && (wdata == COMMIT_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            active_q <= '0;
        end else begin
            if (wr_stage)
                stage_q <= ctl_t'(wdata[CTL_W-1:0]);
            if (key_ok)
                active_q <= stage_q;
        end
    end

endmodule

// File: rtl/memmap_rdmux.sv
module memmap_rdmux
    import memmap_pkg::*;
(
    input  reg_off_e          off,
    input  ctl_t              stage_q,
    input  ctl_t              active_q,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (off)
            OFF_STAGE: rdata = ctl_to_byte(stage_q);
            OFF_KEY:   rdata = '0;
            OFF_MON:   rdata = ctl_to_byte(active_q);
            OFF_STAT:  rdata = ctl_to_status(active_q);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/memmap_overlay.sv
module memmap_overlay #(
    parameter int          ADDR_W   = 16,
    parameter int unsigned WIN_BASE = 32'h1000,
    parameter int unsigned WIN_SIZE = 32'h0800,
    parameter bit          OVL_CODE = 1'b1,
    parameter bit          OVL_DATA = 1'b1
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_data,
    input  logic              boot_en,
    output logic              boot_sel,
    output logic              main_sel
);

    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(WIN_BASE + WIN_SIZE);

    logic [ADDR_W:0] addr_x;
    logic            in_win;
    logic            space_ok;

    assign addr_x   = {1'b0, acc_addr};
    assign in_win   = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
    assign space_ok = acc_is_data ? OVL_DATA : OVL_CODE;

    always_comb begin
        boot_sel = boot_en && in_win && space_ok;
        main_sel = !boot_sel;
    end

endmodule

// File: rtl/memmap_ctl.sv
module memmap_ctl
    import memmap_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int unsigned WIN_BASE = 32'h1000,
    parameter int unsigned WIN_SIZE = 32'h0800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_data,
    output logic              boot_sel,
    output logic              main_sel
);

    reg_off_e off;
    ctl_t     stage_q;
    ctl_t     active_q;
    logic     wr_stage;
    logic     wr_key;

    assign off      = reg_off_e'(bus_addr);
    assign wr_stage = bus_wr && (off == OFF_STAGE);
    assign wr_key   = bus_wr && (off == OFF_KEY);

    memmap_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_stage (wr_stage),
        .wr_key   (wr_key),
        .wdata    (bus_wdata),
        .stage_q  (stage_q),
        .active_q (active_q)
    );

    memmap_rdmux u_rdmux (
        .off      (off),
        .stage_q  (stage_q),
        .active_q (active_q),
        .rdata    (bus_rdata)
    );

    memmap_overlay #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE),
        .OVL_CODE (1'b1),
        .OVL_DATA (1'b1)
    ) u_ovl (
        .acc_addr    (acc_addr),
        .acc_is_data (acc_is_data),
        .boot_en     (active_q.boot),
        .boot_sel    (boot_sel),
        .main_sel    (main_sel)
    );

endmodule

// File: rtl/memmap_ctl_chk.sv
module memmap_ctl_chk
    import memmap_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              boot_sel,
    input logic              main_sel,
    input ctl_t              stage_q,
    input ctl_t              active_q
);

    logic commit;
    assign commit = bus_wr && (bus_addr == OFF_KEY) && (bus_wdata == COMMIT_KEY);

    // R3: a key write loads the staged bits
    assert_commit_loads_R3: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q == $past(stage_q)));

    // R4: no key write, no change to the active copy
    assert_no_commit_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active_q));

    // R2: a staging write is held
    assert_stage_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_STAGE) |=> (stage_q == ctl_t'($past(bus_wdata[CTL_W-1:0]))));

    // R6: upper status bits are zero
    assert_status_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_STAT) |-> (bus_rdata[DATA_W-1:2] == '0));

    // R8: no boot select while the overlay is off
    assert_off_no_boot_R8: assert property (@(posedge clk) disable iff (rst)
        !active_q.boot |-> !boot_sel);

    // R7: boot select only inside the window
    assert_boot_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        boot_sel |-> (acc_addr >= ADDR_W'(16'h1000) && acc_addr <= ADDR_W'(16'h17FF)));

    // R9: exactly one select
    assert_one_select_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({boot_sel, main_sel}) == 1);

endmodule

bind memmap_ctl memmap_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .acc_addr  (acc_addr),
    .boot_sel  (boot_sel),
    .main_sel  (main_sel),
    .stage_q   (stage_q),
    .active_q  (active_q)
);

// File: tb/memmap_ctl_tb.sv
`timescale 1ns/1ps
module memmap_ctl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [15:0] acc_addr;
    logic       acc_is_data;
    logic       boot_sel;
    logic       main_sel;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    memmap_ctl u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .acc_addr    (acc_addr),
        .acc_is_data (acc_is_data),
        .boot_sel    (boot_sel),
        .main_sel    (main_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // one write: driven at the falling edge, captured at the next rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // expected: {main_sel, boot_sel}
    task automatic sel_check(input string req, input logic [15:0] a, input logic dsp,
                             input logic exp_boot);
        acc_addr = a; acc_is_data = dsp;
        #1;
        check(req, {6'b0, main_sel, boot_sel}, {6'b0, !exp_boot, exp_boot});
    endtask

    task automatic t_reset;
        rd_check("R1 stage after reset", 2'd0, 8'h00);
        rd_check("R1 monitor after reset", 2'd2, 8'h00);
        rd_check("R1 status after reset", 2'd3, 8'h00);
        sel_check("R1 no overlay after reset", 16'h1000, 1'b0, 1'b0);
    endtask

    task automatic t_stage_only;
        wr(2'd0, 8'hFF);
        rd_check("R2 stage readback masks bits 7:3", 2'd0, 8'h07);
        rd_check("R2 monitor unchanged by staging", 2'd2, 8'h00);
        sel_check("R2 decoder unchanged by staging", 16'h1400, 1'b0, 1'b0);
        wr(2'd0, 8'h05);
        rd_check("R2 stage readback second value", 2'd0, 8'h05);
    endtask

    task automatic t_bad_key;
        wr(2'd1, 8'hD4);
        rd_check("R4 wrong key leaves monitor", 2'd2, 8'h00);
        wr(2'd1, 8'h55);
        rd_check("R4 wrong key leaves monitor again", 2'd2, 8'h00);
        rd_check("R4 key offset reads zero", 2'd1, 8'h00);
        sel_check("R4 wrong key leaves decoder", 16'h1000, 1'b1, 1'b0);
    endtask

    task automatic t_commit_timing;
        // staging holds 0x05 (boot + vector)
        acc_addr = 16'h1000; acc_is_data = 1'b0;
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'hD5; bus_wr = 1'b1;
        #1;
        check("R3 overlay not yet active before commit edge", {7'b0, boot_sel}, 8'h00);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R3 overlay active the cycle after commit", {7'b0, boot_sel}, 8'h01);
        rd_check("R5 monitor shows committed value", 2'd2, 8'h05);
        rd_check("R6 status shows vector flag only", 2'd3, 8'h02);
    endtask

    task automatic t_window;
        sel_check("R7 below window code", 16'h0FFF, 1'b0, 1'b0);
        sel_check("R7 window low code", 16'h1000, 1'b0, 1'b1);
        sel_check("R7 window high code", 16'h17FF, 1'b0, 1'b1);
        sel_check("R7 above window code", 16'h1800, 1'b0, 1'b0);
        sel_check("R7 window low data", 16'h1000, 1'b1, 1'b1);
        sel_check("R7 window high data", 16'h17FF, 1'b1, 1'b1);
        sel_check("R7 above window data", 16'h1800, 1'b1, 1'b0);
        sel_check("R9 far address main", 16'hFFFF, 1'b1, 1'b0);
    endtask

    task automatic t_status;
        wr(2'd3, 8'hFF);
        rd_check("R6 status write ignored", 2'd3, 8'h02);
        rd_check("R6 status write leaves monitor", 2'd2, 8'h05);
        rd_check("R6 status write leaves stage", 2'd0, 8'h05);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'hD5);
        rd_check("R6 status shows RAM flag", 2'd3, 8'h01);
        rd_check("R5 monitor after second commit", 2'd2, 8'h02);
    endtask

    task automatic t_overlay_off;
        sel_check("R8 off window low code", 16'h1000, 1'b0, 1'b0);
        sel_check("R8 off window high data", 16'h17FF, 1'b1, 1'b0);
        sel_check("R8 off mid window", 16'h1234, 1'b1, 1'b0);
    endtask

    task automatic t_reset_again;
        wr(2'd0, 8'h07);
        wr(2'd1, 8'hD5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_check("R1 monitor cleared by reset", 2'd2, 8'h00);
        rd_check("R1 stage cleared by reset", 2'd0, 8'h00);
        sel_check("R1 overlay cleared by reset", 16'h1000, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        acc_addr = '0; acc_is_data = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stage_only();
        t_bad_key();
        t_commit_timing();
        t_window();
        t_status();
        t_overlay_off();
        t_reset_again();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule